// File: doc/BRIEF.md
# Multi-Source Bidirectional I/O Port

This block sits between a microcontroller register bus and a group of pins (eight by default). For each pin it picks what drives the pin and whether the pin drives at all. The drive value comes from one of three places: a data register that software writes, an output from programmable logic (a macrocell), or one byte of a captured address. The drive enable comes either from a software direction register or from an enable term supplied by the programmable logic.

The address capture is transparent while the address strobe is high and holds its value once the strobe falls. Software can choose the low or the high byte of the held address. The upper half of the pins can act as open-drain outputs: a 1 floats the pin and a 0 pulls it low.

A read multiplexer lets software see the pin levels, the data and direction registers, and the live per-pin driver enables. Pins are split into `pin_in`, `pin_out` and `pin_oe` so that a pad ring can build the tri-state buffer.

Top module: `mmio_port`

## Requirements
- R1: After reset every register is zero. Every pin is then tri-stated (`pin_oe` all 0), and read address 3 returns 0.
- R2: A register is written on a rising clock edge when `bus_wr` is 1, from `bus_wdata`. The write addresses are: 0 data, 1 direction, 2 mode, 3 source-select, 4 byte-select, 5 open-drain. Read address 1 returns the data register and read address 2 returns the direction register. With `bus_wr` at 0, no register changes.
- R3: When a pin's mode bit is 0, the pin drives the data register bit, and its enable is its direction bit.
- R4: When a pin's mode bit is 1 and its source-select bit is 0, the pin drives the macrocell bit `mcell_out[i]`, and its enable is `logic_oe[i]`. The direction register is ignored for that pin.
- R5: When a pin's mode bit is 1 and its source-select bit is 1, the pin drives the captured address. The byte-select value 0 gives bits 7:0 and the value 1 gives bits 15:8.
- R6: While `addr_strobe` is 1, the captured address follows `addr_bus`. After the strobe falls, it keeps the value sampled at the last clock edge with the strobe high, even if `addr_bus` changes.
- R7: For pins 7 to 4 whose open-drain bit is 1, `pin_out` is 0 and `pin_oe` is (enable AND NOT value). Open-drain bits 3 to 0 have no effect.
- R8: Read address 3 returns the live per-pin driver enables, identical to `pin_oe`.
- R9: Read address 0 returns `pin_in`. Read addresses 4 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address for reads and writes |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational from `bus_addr` |
| addr_bus | input | 16 | System address bus |
| addr_strobe | input | 1 | Address latch enable, active high |
| mcell_out | input | 8 | Macrocell output values |
| logic_oe | input | 8 | Logic-supplied per-pin enables |
| pin_in | input | 8 | Pin levels seen from the pad |
| pin_out | output | 8 | Pin drive values |
| pin_oe | output | 8 | Pin driver enables |

## Verification
The bench mixes per-pin modes within one byte. A design that applied the mode to the whole port, or that swapped the direction and logic enables, would show wrong bits in the mixed pattern.

It moves the address bus after the strobe falls. A latch that stayed transparent, or that sampled on the wrong strobe level, would then show the new address instead of the held one.

Open-drain is checked with alternating data bits on the upper pins and with the lower open-drain bits set. An open-drain pin that drove a high level, or lower pins that reacted to their open-drain bits, would be reported. The enable readback is compared with `pin_oe` after open-drain masking, so a readback taken before masking would be caught.

// File: rtl/mmio_port_pkg.sv
package mmio_port_pkg;

    // Register write addresses
    typedef enum logic [2:0] {
        WA_DOUT  = 3'd0,
        WA_DIR   = 3'd1,
        WA_MODE  = 3'd2,
        WA_SRC   = 3'd3,
        WA_BSEL  = 3'd4,
        WA_OD    = 3'd5
    } wr_addr_e;

    // Read addresses
    typedef enum logic [2:0] {
        RA_PINS  = 3'd0,
        RA_DOUT  = 3'd1,
        RA_DIR   = 3'd2,
        RA_OEN   = 3'd3
    } rd_addr_e;

endpackage

// File: rtl/mmio_regfile.sv
module mmio_regfile #(
    parameter int W     = 8,
    parameter int SEL_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [2:0]       addr,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     dout,
    output logic [W-1:0]     dir,
    output logic [W-1:0]     mode,
    output logic [W-1:0]     src,
    output logic [W-1:0]     od,
    output logic [SEL_W-1:0] bsel
);
    import mmio_port_pkg::*;

    typedef struct packed {
        logic [W-1:0]     dout;
        logic [W-1:0]     dir;
        logic [W-1:0]     mode;
        logic [W-1:0]     src;
        logic [W-1:0]     od;
        logic [SEL_W-1:0] bsel;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr) begin
            unique case (addr)
                WA_DOUT: r_d.dout = wdata;
                WA_DIR:  r_d.dir  = wdata;
                WA_MODE: r_d.mode = wdata;
                WA_SRC:  r_d.src  = wdata;
                WA_BSEL: r_d.bsel = wdata[SEL_W-1:0];
                WA_OD:   r_d.od   = wdata;
                default: r_d = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign dout = r_q.dout;
    assign dir  = r_q.dir;
    assign mode = r_q.mode;
    assign src  = r_q.src;
    assign od   = r_q.od;
    assign bsel = r_q.bsel;

endmodule

// File: rtl/mmio_addr_latch.sv
module mmio_addr_latch #(
    parameter int W      = 8,
    parameter int ABUS_W = 16,
    parameter int SEL_W  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [ABUS_W-1:0] abus,
    input  logic [SEL_W-1:0]  bsel,
    output logic [ABUS_W-1:0] held,
    output logic [W-1:0]      byte_out
);
    localparam int NBYTES = ABUS_W / W;

    logic [ABUS_W-1:0] held_d, held_q;
    logic [ABUS_W-1:0] view;

    always_comb begin
        held_d = strobe ? abus : held_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) held_q <= '0;
        else        held_q <= held_d;
    end

    // Transparent while strobe high, held otherwise
    assign view = strobe ? abus : held_q;
    assign held = held_q;

    always_comb begin
        byte_out = '0;
        for (int b = 0; b < NBYTES; b++) begin
            if (int'(bsel) == b) byte_out = view[b*W +: W];
        end
    end

endmodule

// File: rtl/mmio_pin_slice.sv
module mmio_pin_slice #(
    parameter bit OD_OK = 1'b0
) (
    input  logic mode,
    input  logic src,
    input  logic dout_bit,
    input  logic dir_bit,
    input  logic mcell_bit,
    input  logic loe_bit,
    input  logic addr_bit,
    input  logic od_bit,
    output logic pin_out,
    output logic pin_oe
);
    logic val, en, od_en;

    always_comb begin
        if (!mode) begin
            val = dout_bit;
            en  = dir_bit;
        end else begin
            val = src ? addr_bit : mcell_bit;
            en  = loe_bit;
        end
        od_en = OD_OK && od_bit;
        if (od_en) begin
            pin_out = 1'b0;
            pin_oe  = en & ~val;
        end else begin
            pin_out = val;
            pin_oe  = en;
        end
    end

endmodule

// File: rtl/mmio_port.sv
module mmio_port #(
    parameter int W      = 8,
    parameter int ABUS_W = 16,
    parameter int OD_LO  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      rd_data,
    input  logic [ABUS_W-1:0] addr_bus,
    input  logic              addr_strobe,
    input  logic [W-1:0]      mcell_out,
    input  logic [W-1:0]      logic_oe,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_oe
);
    import mmio_port_pkg::*;

    localparam int NBYTES = ABUS_W / W;
    localparam int SEL_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    logic [W-1:0]      dout_q, dir_q, mode_q, src_q, od_q;
    logic [SEL_W-1:0]  bsel_q;
    logic [ABUS_W-1:0] held_addr;
    logic [W-1:0]      addr_byte;

    mmio_regfile #(.W(W), .SEL_W(SEL_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .dout  (dout_q),
        .dir   (dir_q),
        .mode  (mode_q),
        .src   (src_q),
        .od    (od_q),
        .bsel  (bsel_q)
    );

    mmio_addr_latch #(.W(W), .ABUS_W(ABUS_W), .SEL_W(SEL_W)) u_alat (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (addr_strobe),
        .abus     (addr_bus),
        .bsel     (bsel_q),
        .held     (held_addr),
        .byte_out (addr_byte)
    );

    for (genvar i = 0; i < W; i++) begin : g_pin
        mmio_pin_slice #(.OD_OK(i >= OD_LO)) u_slice (
            .mode      (mode_q[i]),
            .src       (src_q[i]),
            .dout_bit  (dout_q[i]),
            .dir_bit   (dir_q[i]),
            .mcell_bit (mcell_out[i]),
            .loe_bit   (logic_oe[i]),
            .addr_bit  (addr_byte[i]),
            .od_bit    (od_q[i]),
            .pin_out   (pin_out[i]),
            .pin_oe    (pin_oe[i])
        );
    end

    always_comb begin
        unique case (bus_addr)
            RA_PINS: rd_data = pin_in;
            RA_DOUT: rd_data = dout_q;
            RA_DIR:  rd_data = dir_q;
            RA_OEN:  rd_data = pin_oe;
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/mmio_port_chk.sv
module mmio_port_chk #(
    parameter int W      = 8,
    parameter int ABUS_W = 16,
    parameter int OD_LO  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        bus_addr,
    input logic              bus_wr,
    input logic [W-1:0]      bus_wdata,
    input logic [W-1:0]      rd_data,
    input logic              addr_strobe,
    input logic [W-1:0]      pin_out,
    input logic [W-1:0]      pin_oe,
    input logic [W-1:0]      dout_q,
    input logic [W-1:0]      dir_q,
    input logic [W-1:0]      mode_q,
    input logic [W-1:0]      od_q,
    input logic [ABUS_W-1:0] held_addr
);
    localparam logic [W-1:0] OD_MASK = {W{1'b1}} << OD_LO;

    // R2: data register takes the written value
    p_wr_dout_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd0) |=> dout_q == $past(bus_wdata));

    // R3: software mode without open-drain follows data and direction
    p_mcu_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == '0 && (od_q & OD_MASK) == '0) |-> (pin_oe == dir_q && pin_out == dout_q));

    // R6: held address stays put while strobe low
    p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_strobe && $past(!addr_strobe)) |-> $stable(held_addr));

    // R7: open-drain pins never drive high
    p_od_no_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & pin_out & od_q & OD_MASK) == '0);

    // R8: enable readback is live
    p_eo_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 3'd3) |-> rd_data == pin_oe);

    // R9: unused read addresses give zero
    p_rd_unused_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr >= 3'd4) |-> rd_data == '0);

endmodule

bind mmio_port mmio_port_chk #(.W(W), .ABUS_W(ABUS_W), .OD_LO(OD_LO)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .rd_data     (rd_data),
    .addr_strobe (addr_strobe),
    .pin_out     (pin_out),
    .pin_oe      (pin_oe),
    .dout_q      (dout_q),
    .dir_q       (dir_q),
    .mode_q      (mode_q),
    .od_q        (od_q),
    .held_addr   (held_addr)
);

// File: tb/mmio_port_tb.sv
module mmio_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  rd_data;
    logic [15:0] addr_bus = '0;
    logic        addr_strobe = 1'b0;
    logic [7:0]  mcell_out = '0;
    logic [7:0]  logic_oe = '0;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out;
    logic [7:0]  pin_oe;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mmio_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .rd_data(rd_data), .addr_bus(addr_bus),
        .addr_strobe(addr_strobe), .mcell_out(mcell_out), .logic_oe(logic_oe),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = rd_data;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 oe", pin_oe, 8'h00);
        rd(3'd3, v); chk("R1 enable-out", v, 8'h00);
        rd(3'd1, v); chk("R1 data reg", v, 8'h00);
        rd(3'd2, v); chk("R1 dir reg", v, 8'h00);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        wr(3'd0, 8'hA5); wr(3'd1, 8'h3C);
        rd(3'd1, v); chk("R2 data rb", v, 8'hA5);
        rd(3'd2, v); chk("R2 dir rb", v, 8'h3C);
        @(negedge clk); bus_addr = 3'd0; bus_wdata = 8'hFF; bus_wr = 1'b0;
        @(negedge clk);
        rd(3'd1, v); chk("R2 no write", v, 8'hA5);
    endtask

    task automatic t_mcu_mode();
        wr(3'd0, 8'h96); wr(3'd1, 8'hF0);
        @(negedge clk); #1;
        chk("R3 out", pin_out, 8'h96);
        chk("R3 oe", pin_oe, 8'hF0);
    endtask

    task automatic t_logic_mode();
        wr(3'd2, 8'hFF); wr(3'd3, 8'h00); wr(3'd1, 8'hFF);
        mcell_out = 8'h3C; logic_oe = 8'h0F;
        @(negedge clk); #1;
        chk("R4 out", pin_out, 8'h3C);
        chk("R4 oe", pin_oe, 8'h0F);
        // mixed: upper pins logic, lower pins software
        wr(3'd2, 8'hF0); wr(3'd1, 8'h33); wr(3'd0, 8'h81);
        @(negedge clk); #1;
        chk("R4 R3 mixed out", pin_out, 8'h31);
        chk("R4 R3 mixed oe", pin_oe, 8'h03);
    endtask

    task automatic t_addr_mode();
        wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd4, 8'h00);
        logic_oe = 8'hFF;
        addr_bus = 16'hBEEF; addr_strobe = 1'b1;
        @(negedge clk); #1;
        chk("R5 low byte", pin_out, 8'hEF);
        wr(3'd4, 8'h01);
        #1 chk("R5 high byte", pin_out, 8'hBE);
    endtask

    task automatic t_latch_hold();
        @(negedge clk); addr_bus = 16'h1234; addr_strobe = 1'b1;
        @(negedge clk); #1;
        chk("R6 transparent", pin_out, 8'h12);
        addr_strobe = 1'b0;
        @(negedge clk); addr_bus = 16'hFFFF;
        @(negedge clk); #1;
        chk("R6 held high", pin_out, 8'h12);
        wr(3'd4, 8'h00);
        #1 chk("R6 held low", pin_out, 8'h34);
    endtask

    task automatic t_open_drain();
        logic [7:0] v;
        wr(3'd2, 8'h00); wr(3'd1, 8'hFF); wr(3'd0, 8'h5A); wr(3'd5, 8'hF0);
        @(negedge clk); #1;
        chk("R7 out", pin_out, 8'h0A);
        chk("R7 oe", pin_oe, 8'hAF);
        rd(3'd3, v); chk("R8 enable-out od", v, 8'hAF);
        wr(3'd5, 8'hFF);
        @(negedge clk); #1;
        chk("R7 low od ignored out", pin_out, 8'h0A);
        chk("R7 low od ignored oe", pin_oe, 8'hAF);
        wr(3'd5, 8'h00);
    endtask

    task automatic t_readback();
        logic [7:0] v;
        wr(3'd2, 8'hFF); wr(3'd3, 8'h00); logic_oe = 8'h69;
        rd(3'd3, v); chk("R8 enable-out logic", v, 8'h69);
        pin_in = 8'hC3;
        rd(3'd0, v); chk("R9 pins", v, 8'hC3);
        for (int a = 4; a < 8; a++) begin
            rd(3'(a), v); chk("R9 unused", v, 8'h00);
        end
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset();
        t_regs();
        t_mcu_mode();
        t_logic_mode();
        t_addr_mode();
        t_latch_hold();
        t_open_drain();
        t_readback();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule